// File: doc/BRIEF.md
# One-Shot Frame Update Controller

This block decides when each of two display channels, a main panel and a sub panel, begins transferring a frame. It also collects the frame events into one shared interrupt. Each channel runs in one of two modes. In continuous mode the channel restarts a frame as soon as the previous one has ended. In one-shot mode a frame starts only when software has asked for one, so a panel with its own frame memory is refreshed only when its picture has changed. The scan engine of each channel reports the end of its frame on a done strobe. The controller answers with a one-cycle frame-start strobe.

Software reaches the block through a plain register bus. It has a write strobe, a read strobe, an address, write data and registered read data. All pins are control or status: no data stream passes through the block, so there is no valid/ready handshake and no back-pressure. A single interrupt register holds sticky event flags in its low byte and enable bits above them. A separate status register records which channel produced the most recent frame end, so one interrupt handler can serve both panels.

Register map, by byte address:

- 0x00: interrupt register. Bit 0 is the frame-end flag and bit 2 is the frame-start flag. Bit 8 enables the frame-start flag and bit 10 enables the frame-end flag.
- 0x04: source register. Bit 10 tells which channel produced the last frame end.
- 0x08: mode register. Bit 0 sets the main channel's mode and bit 1 sets the sub channel's mode. A bit at 1 means one-shot and a bit at 0 means continuous.
- 0x10: main-channel trigger. Only bit 0 is used.
- 0x14: sub-channel trigger. Only bit 0 is used.

Top module: `frame_update_ctrl`

## Requirements
- R1: After reset the following hold: the mode register (0x08) reads 0, so both channels are continuous; the source register (0x04) reads 0; both trigger registers read 0; irq_o is 0; every enable bit of the interrupt register (0x00) is 0 and so is its bit 0.
- R2: A continuous channel that is idle drives its frame_start_o bit high for exactly one cycle. A done strobe seen while that channel's frame runs ends the frame, and the next start pulse appears after the second clock edge that follows.
- R3: A one-shot channel starts a frame only on request. Writing a 1 to bit 0 of its trigger register (0x10 for main, 0x14 for sub) starts exactly one frame. Once that frame ends, no further start follows without a new request.
- R4: A trigger written while a one-shot frame of that channel is running is held and starts one more frame after the current one ends. Several triggers written during one frame add only one more frame.
- R5: Bit 0 of a trigger register reads 1 while a one-shot request is pending or a one-shot frame is running, and 0 otherwise. In continuous mode a trigger write has no effect and the register reads 0.
- R6: A done strobe on a channel with no frame running is ignored. It sets no flag, changes no source bit and starts no frame.
- R7: Interrupt-register bit 0 is set by every accepted frame end on either channel. Bit 2 is set on the clock edge that ends any frame_start_o pulse. Both bits stay set until software clears them.
- R8: A write to the interrupt register clears each status bit (0 and 2) where the written bit is 0 and leaves it unchanged where the written bit is 1. An event in the same cycle wins over the clear. The same write loads enable bits 8 and 10. All other bits read 0.
- R9: irq_o is high exactly when (bit 0 and bit 10) or (bit 2 and bit 8) of the interrupt register are both 1.
- R10: Source-register bit 10 becomes 1 when a frame end is accepted on the sub channel and 0 when one is accepted on the main channel alone. When both end in the same cycle, it becomes 1.
- R11: bus_rdata carries the value of the addressed register in the cycle after bus_rd is high, and is 0 in any other cycle. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| frame_done_i | input | 2 | Frame-end strobe from each scan engine (bit 0 main, bit 1 sub) |
| frame_start_o | output | 2 | One-cycle frame-start pulse to each scan engine |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The assertions check properties that must hold on every cycle:

- every start pulse lasts one cycle;
- a one-shot start is always preceded by a pending request;
- a trigger written during a running frame is latched;
- a busy channel stays busy until its done strobe;
- the frame-end flag is sticky and clears where a 0 is written;
- a sub-channel frame end always sets the source bit;
- read data falls to zero when no read is issued.

The bench's scenarios are needed for properties that span several cycles:

- the exact number of frames produced by bursts of triggers;
- the silence of a one-shot channel with no request;
- trigger writes being ignored in continuous mode;
- stray done strobes;
- the full value read back from each register after a sequence of set, clear and enable writes.

// File: rtl/fuc_pkg.sv
package fuc_pkg;
  localparam int NUM_CH  = 2;
  localparam int CH_MAIN = 0;
  localparam int CH_SUB  = 1;

  // register byte addresses
  localparam int A_INT       = 'h00;
  localparam int A_SRC       = 'h04;
  localparam int A_MODE      = 'h08;
  localparam int A_TRIG_MAIN = 'h10;
  localparam int A_TRIG_SUB  = 'h14;

  // bit positions
  localparam int B_FE_ST   = 0;
  localparam int B_FS_ST   = 2;
  localparam int B_FS_EN   = 8;
  localparam int B_FE_EN   = 10;
  localparam int B_SRC_SUB = 10;
endpackage

// File: rtl/fuc_chan.sv
module fuc_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic oneshot_i,
  input  logic trig_i,
  input  logic done_i,
  output logic start_o,
  output logic end_o,
  output logic busy_o
);
  logic run_q;
  logic os_q;
  logic pend_q;
  logic go;
  logic trig_acc;

  // a request only counts in one-shot mode
  assign trig_acc = trig_i & oneshot_i;
  // an idle channel starts when continuous, or when a request is waiting
  assign go       = ~run_q & (~oneshot_i | pend_q);
  assign end_o    = run_q & done_i;
  assign busy_o   = pend_q | os_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      os_q    <= 1'b0;
      pend_q  <= 1'b0;
      start_o <= 1'b0;
    end else begin
      start_o <= go;
      if (go) begin
        run_q  <= 1'b1;
        os_q   <= oneshot_i;
        pend_q <= trig_acc;
      end else begin
        pend_q <= pend_q | trig_acc;
        if (end_o) begin
          run_q <= 1'b0;
          os_q  <= 1'b0;
        end
      end
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);  // R2
  AST_OS_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && os_q) |-> $past(pend_q));  // R3
  AST_TRIG_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && trig_acc) |=> pend_q);  // R4
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (os_q && !done_i) |=> busy_o);  // R5
endmodule

// File: rtl/fuc_irq.sv
module fuc_irq
  import fuc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fs_evt_i,
  input  logic              fe_main_i,
  input  logic              fe_sub_i,
  output logic [DATA_W-1:0] int_rd_o,
  output logic [DATA_W-1:0] src_rd_o,
  output logic              irq_o
);
  logic st_fe_q, st_fs_q, en_fe_q, en_fs_q, src_sub_q;
  logic st_fe_d, st_fs_d;
  logic fe_evt;

  assign fe_evt = fe_main_i | fe_sub_i;

  // write-zero-to-clear, with a same-cycle event winning
  always_comb begin
    st_fe_d = st_fe_q;
    st_fs_d = st_fs_q;
    if (wr_i) begin
      st_fe_d = st_fe_q & wdata_i[B_FE_ST];
      st_fs_d = st_fs_q & wdata_i[B_FS_ST];
    end
    if (fe_evt)   st_fe_d = 1'b1;
    if (fs_evt_i) st_fs_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_fe_q   <= 1'b0;
      st_fs_q   <= 1'b0;
      en_fe_q   <= 1'b0;
      en_fs_q   <= 1'b0;
      src_sub_q <= 1'b0;
    end else begin
      st_fe_q <= st_fe_d;
      st_fs_q <= st_fs_d;
      if (wr_i) begin
        en_fe_q <= wdata_i[B_FE_EN];
        en_fs_q <= wdata_i[B_FS_EN];
      end
      if (fe_sub_i)       src_sub_q <= 1'b1;
      else if (fe_main_i) src_sub_q <= 1'b0;
    end
  end

  always_comb begin
    int_rd_o           = '0;
    int_rd_o[B_FE_ST]  = st_fe_q;
    int_rd_o[B_FS_ST]  = st_fs_q;
    int_rd_o[B_FE_EN]  = en_fe_q;
    int_rd_o[B_FS_EN]  = en_fs_q;
    src_rd_o           = '0;
    src_rd_o[B_SRC_SUB] = src_sub_q;
  end

  assign irq_o = (st_fe_q & en_fe_q) | (st_fs_q & en_fs_q);

  AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fe_q && !wr_i) |=> st_fe_q);  // R7
  AST_CLEAR_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !wdata_i[B_FE_ST] && !fe_evt) |=> !st_fe_q);  // R8
  AST_SRC_FOLLOWS_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    fe_sub_i |=> src_sub_q);  // R10
endmodule

// File: rtl/frame_update_ctrl.sv
module frame_update_ctrl
  import fuc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] frame_done_i,
  output logic [NUM_CH-1:0] frame_start_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] mode_q;
  logic [NUM_CH-1:0] ch_end;
  logic [NUM_CH-1:0] ch_busy;
  logic [NUM_CH-1:0] trig_hit;
  logic [DATA_W-1:0] int_rd, src_rd, rd_val;
  logic              wr_int, wr_mode;

  assign wr_int  = bus_wr & (bus_addr == ADDR_W'(A_INT));
  assign wr_mode = bus_wr & (bus_addr == ADDR_W'(A_MODE));

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= '0;
    else if (wr_mode) mode_q <= bus_wdata[NUM_CH-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int TA = (c == CH_SUB) ? A_TRIG_SUB : A_TRIG_MAIN;
    assign trig_hit[c] = bus_wr & (bus_addr == ADDR_W'(TA)) & bus_wdata[0];
    fuc_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .oneshot_i (mode_q[c]),
      .trig_i    (trig_hit[c]),
      .done_i    (frame_done_i[c]),
      .start_o   (frame_start_o[c]),
      .end_o     (ch_end[c]),
      .busy_o    (ch_busy[c])
    );
  end

  fuc_irq #(.DATA_W(DATA_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (wr_int),
    .wdata_i   (bus_wdata),
    .fs_evt_i  (|frame_start_o),
    .fe_main_i (ch_end[CH_MAIN]),
    .fe_sub_i  (ch_end[CH_SUB]),
    .int_rd_o  (int_rd),
    .src_rd_o  (src_rd),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_val = '0;
    if (bus_addr == ADDR_W'(A_INT))            rd_val = int_rd;
    else if (bus_addr == ADDR_W'(A_SRC))       rd_val = src_rd;
    else if (bus_addr == ADDR_W'(A_MODE))      rd_val[NUM_CH-1:0] = mode_q;
    else if (bus_addr == ADDR_W'(A_TRIG_MAIN)) rd_val[0] = ch_busy[CH_MAIN];
    else if (bus_addr == ADDR_W'(A_TRIG_SUB))  rd_val[0] = ch_busy[CH_SUB];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));  // R11
endmodule

// File: tb/frame_update_ctrl_tb_top.sv
module frame_update_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] AD_INT = 8'h00, AD_SRC = 8'h04, AD_MODE = 8'h08;
  localparam logic [7:0] AD_TM = 8'h10, AD_TS = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  frame_done = '0;
  logic [1:0]  frame_start;
  logic        irq;

  int total = 0, bad = 0, cyc = 0;
  bit cmp_en = 0, finished = 0;
  int cnt_st[2];

  // reference model state
  int m_st0, m_st2, m_en_fe, m_en_fs, m_src;
  int m_mode[2], m_run[2], m_ros[2], m_pend[2], m_start[2];
  int m_rdata;
  int t_acc[2], t_go[2], t_tg[2];
  int n_st0, n_st2;

  frame_update_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_done_i(frame_done), .frame_start_o(frame_start), .irq_o(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int model_read(logic [7:0] a);
    case (a)
      AD_INT:  return (m_en_fe << 10) | (m_en_fs << 8) | (m_st2 << 2) | m_st0;
      AD_SRC:  return m_src << 10;
      AD_MODE: return (m_mode[1] << 1) | m_mode[0];
      AD_TM:   return (m_pend[0] | m_ros[0]);
      AD_TS:   return (m_pend[1] | m_ros[1]);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st0 = 0; m_st2 = 0; m_en_fe = 0; m_en_fs = 0; m_src = 0; m_rdata = 0;
      for (int c = 0; c < 2; c++) begin
        m_mode[c] = 0; m_run[c] = 0; m_ros[c] = 0; m_pend[c] = 0; m_start[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        t_acc[c] = m_run[c] & int'(frame_done[c]);
        t_go[c]  = (m_run[c] == 0) && (m_mode[c] == 0 || m_pend[c] != 0);
        t_tg[c]  = bus_wr && bus_addr == (c ? AD_TS : AD_TM) && bus_wdata[0] && m_mode[c] != 0;
      end
      m_rdata = bus_rd ? model_read(bus_addr) : 0;
      n_st0 = m_st0; n_st2 = m_st2;
      if (bus_wr && bus_addr == AD_INT) begin
        n_st0 = m_st0 & int'(bus_wdata[0]);
        n_st2 = m_st2 & int'(bus_wdata[2]);
        m_en_fe = bus_wdata[10];
        m_en_fs = bus_wdata[8];
      end
      if (t_acc[0] || t_acc[1]) n_st0 = 1;
      if (m_start[0] || m_start[1]) n_st2 = 1;
      m_st0 = n_st0; m_st2 = n_st2;
      if (t_acc[1]) m_src = 1; else if (t_acc[0]) m_src = 0;
      for (int c = 0; c < 2; c++) begin
        m_start[c] = t_go[c];
        if (t_go[c]) begin
          m_run[c] = 1; m_ros[c] = m_mode[c]; m_pend[c] = t_tg[c];
        end else begin
          if (t_tg[c]) m_pend[c] = 1;
          if (t_acc[c]) begin m_run[c] = 0; m_ros[c] = 0; end
        end
      end
      if (bus_wr && bus_addr == AD_MODE) begin
        m_mode[0] = bus_wdata[0]; m_mode[1] = bus_wdata[1];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_en) begin
      for (int c = 0; c < 2; c++)
        check(int'(frame_start[c]) == m_start[c], "R2 R3 frame_start vs model",
              int'(frame_start[c]), m_start[c]);
      check(int'(irq) == ((m_st0 & m_en_fe) | (m_st2 & m_en_fs)), "R9 irq vs model",
            int'(irq), (m_st0 & m_en_fe) | (m_st2 & m_en_fs));
      check(bus_rdata == 32'(m_rdata), "R11 rdata vs model", bus_rdata, m_rdata);
    end
    if (rst_n) for (int c = 0; c < 2; c++) if (frame_start[c]) cnt_st[c]++;
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=%0d exp=0", cyc);
      finish_run();
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; bus_addr = '0; v = bus_rdata;
  endtask

  task automatic pulse_done(input logic [1:0] m);
    @(negedge clk); frame_done = m;
    @(negedge clk); frame_done = '0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v;
  int c0, c1;

  initial begin
    cnt_st[0] = 0; cnt_st[1] = 0;
    repeat (3) @(negedge clk);
    check(frame_start == 2'b00, "R1 start low in reset", frame_start, 0);
    check(irq == 1'b0, "R1 irq low in reset", irq, 0);
    rst_n = 1;
    @(negedge clk);
    cmp_en = 1;

    // R1 reset state through the bus
    rd(AD_MODE, v); check(v == 0, "R1 mode reset", v, 0);
    rd(AD_SRC, v);  check(v == 0, "R1 src reset", v, 0);
    rd(AD_TM, v);   check(v == 0, "R1 trig main reset", v, 0);
    rd(AD_INT, v);  check((v & 32'hFFFF_FFFB) == 0, "R1 int reset", v, 0);

    // R2 continuous restart after each done
    c0 = cnt_st[0]; c1 = cnt_st[1];
    pulse_done(2'b11); wait_cyc(4);
    check(cnt_st[0] == c0 + 1, "R2 main restarts", cnt_st[0], c0 + 1);
    check(cnt_st[1] == c1 + 1, "R2 sub restarts", cnt_st[1], c1 + 1);

    // R3 switch to one-shot, no self start
    wr(AD_MODE, 32'h3);
    pulse_done(2'b11);
    c0 = cnt_st[0]; c1 = cnt_st[1];
    wait_cyc(10);
    check(cnt_st[0] == c0 && cnt_st[1] == c1, "R3 idle without request", cnt_st[0], c0);
    rd(AD_TM, v); check(v == 0, "R5 trig reads 0 when idle", v, 0);

    // R8 R9 enables and write-zero clearing (both flags set by now)
    wr(AD_INT, 32'h0000_04FF);
    rd(AD_INT, v); check(v == 32'h405, "R8 ones keep flags", v, 32'h405);
    check(irq == 1, "R9 irq from frame end", irq, 1);
    wr(AD_INT, 32'h0000_04FE);
    rd(AD_INT, v); check(v == 32'h404, "R8 zero clears bit0", v, 32'h404);
    check(irq == 0, "R9 irq drops", irq, 0);
    wr(AD_INT, 32'h0000_05FF);
    check(irq == 1, "R9 irq from frame start", irq, 1);
    wr(AD_INT, 32'h0000_05FB);
    rd(AD_INT, v); check(v == 32'h500, "R8 zero clears bit2", v, 32'h500);
    wr(AD_TM, 32'h1); wait_cyc(3);
    check(irq == 1, "R7 R9 start flag raises irq", irq, 1);
    pulse_done(2'b01); wait_cyc(2);
    wr(AD_INT, 32'h0);
    rd(AD_INT, v); check(v == 0, "R8 clear all", v, 0);

    // R3 R5 single one-shot frame
    c0 = cnt_st[0];
    wr(AD_TM, 32'h1);
    rd(AD_TM, v); check(v == 1, "R5 busy after trigger", v, 1);
    wait_cyc(2);
    check(cnt_st[0] == c0 + 1, "R3 one frame started", cnt_st[0], c0 + 1);
    pulse_done(2'b01); wait_cyc(5);
    check(cnt_st[0] == c0 + 1, "R3 no extra frame", cnt_st[0], c0 + 1);
    rd(AD_TM, v); check(v == 0, "R5 idle after frame", v, 0);
    rd(AD_INT, v); check(v == 32'h5, "R7 both flags sticky", v, 32'h5);

    // R4 triggers during a frame add one frame
    c0 = cnt_st[0];
    wr(AD_TM, 32'h1); wait_cyc(3);
    wr(AD_TM, 32'h1); wr(AD_TM, 32'h1);
    pulse_done(2'b01); wait_cyc(4);
    check(cnt_st[0] == c0 + 2, "R4 latched extra frame", cnt_st[0], c0 + 2);
    rd(AD_TM, v); check(v == 1, "R5 busy in second frame", v, 1);
    pulse_done(2'b01); wait_cyc(5);
    check(cnt_st[0] == c0 + 2, "R4 only one extra", cnt_st[0], c0 + 2);

    // R6 stray done while idle
    wr(AD_INT, 32'h0);
    c0 = cnt_st[0];
    pulse_done(2'b11); wait_cyc(2);
    rd(AD_INT, v); check(v == 0, "R6 stray done sets nothing", v, 0);
    check(cnt_st[0] == c0, "R6 no start from stray done", cnt_st[0], c0);

    // R10 source channel
    wr(AD_TS, 32'h1); wait_cyc(3); pulse_done(2'b10); wait_cyc(2);
    rd(AD_SRC, v); check(v == 32'h400, "R10 sub source", v, 32'h400);
    wr(AD_TM, 32'h1); wait_cyc(3); pulse_done(2'b01); wait_cyc(2);
    rd(AD_SRC, v); check(v == 0, "R10 main source", v, 0);
    wr(AD_TM, 32'h1); wr(AD_TS, 32'h1); wait_cyc(3); pulse_done(2'b11); wait_cyc(2);
    rd(AD_SRC, v); check(v == 32'h400, "R10 both gives sub", v, 32'h400);

    // R5 trigger ignored in continuous mode
    wr(AD_MODE, 32'h2);
    wr(AD_TM, 32'h1);
    rd(AD_TM, v); check(v == 0, "R5 continuous ignores trigger", v, 0);
    pulse_done(2'b01); wait_cyc(2);

    // R11 unmapped and mode readback
    rd(8'h3C, v); check(v == 0, "R11 unmapped reads 0", v, 0);
    rd(AD_MODE, v); check(v == 2, "R11 mode readback", v, 2);
    wait_cyc(3);
    finish_run();
  end
endmodule